// File: doc/BRIEF.md
# Interrupt Trigger Configuration Bank

This block stores the trigger configuration of every interrupt line of an interrupt distributor. Each line owns a 2-bit field. The upper bit picks edge (1) or level (0) triggering. The lower bit is the handling-model bit, and the block keeps it only when the legacy-revision parameter is set. Software reaches the fields through a byte-wide port. One byte carries the fields of four consecutive interrupts, and the field of the k-th interrupt in a byte sits at bits [2k+1:2k].

The configuration window covers byte offsets 0xC00 up to 0xEFF. The first interrupt of a byte is (offset − 0xC00) × 4 + BASE_IRQ. The first sixteen interrupts are software-generated, and their trigger bits are fixed at edge: any write to one of their bytes is ORed with 0xAA before it is stored. Private peripheral interrupts (16–31) and shared ones are freely writable. If a byte's first interrupt number is at or beyond NUM_IRQ, the access is refused and the error flag is raised. The distributor reads the live configuration from two flat per-interrupt vectors.

Top module: `irq_trig_cfg`

## Requirements
- R1: After reset, interrupts 0–15 have edge bit 1, and every other interrupt has edge bit 0. Every model bit is 0.
- R2: A write to a valid byte at offset A updates interrupts n..n+3, where n=(A−0xC00)*4+BASE_IRQ. The upper bit of field k (value bit 2k+1) becomes that interrupt's edge bit. The change is visible on the edge vector on the clock edge that samples the write strobe.
- R3: When n<16, the stored edge bits of the byte are always 1, whatever the written data (the data is ORed with 0xAA).
- R4: Interrupts 16–31 keep whatever edge bit was written, including 0.
- R5: With LEGACY=1, the lower bit of field k (value bit 2k) is stored as the model bit. With LEGACY=0, that bit is ignored and the model vector stays 0.
- R6: A read of a valid byte returns, one cycle after the read strobe, the packed fields {model,edge order: bit 2k+1 = edge, bit 2k = model} of its four interrupts. Interrupts at or beyond NUM_IRQ read as 0.
- R7: When n≥NUM_IRQ, an access inside the window raises err for one cycle in the cycle after the strobe, and no state changes. A valid access gives err=0.
- R8: An access outside 0xC00–0xEFF changes no state, does not raise err, and leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset |
| wdata | input | 8 | Write byte |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read byte |
| err | output | 1 | Bad-register flag, registered |
| edge_trig | output | NUM_IRQ | 1 = edge-triggered, per interrupt |
| model | output | NUM_IRQ | Handling-model bit, per interrupt |

## Verification
The bench runs random accesses against a model computed in the bench. It also targets specific corners:
- The boundary between software-generated and peripheral interrupts at offset 0xC04. A design that forced too wide a range would pin interrupts 16–31 to edge.
- The last valid byte and the first invalid byte. An off-by-one in the bounds check would either corrupt no state but flag err wrongly, or write past the array.
- The read field packing. A design that computed the interrupt number at two per byte would return the wrong interrupts.
- Writes to the model bit in both parameter settings. A design that stored it unconditionally would light the model vector in the non-legacy build.

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
  parameter int NUM_IRQ  = 96,
  parameter int BASE_IRQ = 0,
  parameter bit LEGACY   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        addr,
  input  logic [7:0]         wdata,
  input  logic               wr,
  input  logic               rd,
  output logic [7:0]         rdata,
  output logic               err,
  output logic [NUM_IRQ-1:0] edge_trig,
  output logic [NUM_IRQ-1:0] model
);
  localparam int NUM_SGI = 16;
  localparam logic [11:0] WIN_LO = 12'hC00;
  localparam logic [11:0] WIN_HI = 12'hF00;

  logic        in_win;
  logic [31:0] first_irq;
  logic        bad;
  logic [7:0]  wval;

  assign in_win    = (addr >= WIN_LO) && (addr < WIN_HI);
  assign first_irq = 32'(addr - WIN_LO) * 4 + BASE_IRQ;
  assign bad       = first_irq >= NUM_IRQ;
  assign wval      = (first_irq < NUM_SGI) ? (wdata | 8'hAA) : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        edge_trig[i] <= (i < NUM_SGI);
        model[i]     <= 1'b0;
      end
    end else if (wr && in_win && !bad) begin
      for (int k = 0; k < 4; k++) begin
        if (first_irq + k < NUM_IRQ) begin
          edge_trig[first_irq + k] <= wval[2*k+1];
          if (LEGACY) model[first_irq + k] <= wval[2*k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= (wr || rd) && in_win && bad;
      if (rd && in_win && !bad) begin
        for (int k = 0; k < 4; k++) begin
          if (first_irq + k < NUM_IRQ) begin
            rdata[2*k+1] <= edge_trig[first_irq + k];
            rdata[2*k]   <= LEGACY ? model[first_irq + k] : 1'b0;
          end else begin
            rdata[2*k+1] <= 1'b0;
            rdata[2*k]   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module irq_trig_cfg_chk #(
  parameter int NUM_IRQ = 96,
  parameter bit LEGACY  = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [11:0]        addr,
  input logic               wr,
  input logic               rd,
  input logic [7:0]         rdata,
  input logic               err,
  input logic [NUM_IRQ-1:0] edge_trig,
  input logic [NUM_IRQ-1:0] model
);
  logic win;
  assign win = (addr >= 12'hC00) && (addr < 12'hF00);

  assert_sgi_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_trig[15:0] == 16'hFFFF);
  assert_model_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !LEGACY |-> model == '0);
  assert_no_err_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> !err);
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd || !win) |=> $stable(rdata));
  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr || !win) |=> $stable(edge_trig) && $stable(model));
endmodule

bind irq_trig_cfg irq_trig_cfg_chk #(.NUM_IRQ(NUM_IRQ), .LEGACY(LEGACY)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .rdata(rdata),
  .err(err), .edge_trig(edge_trig), .model(model));

// File: tb/test_irq_trig_cfg.sv
module test_irq_trig_cfg;
  localparam int N = 96;
  localparam bit LEG = 1'b1;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [11:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, rdata0;
  logic err, err0;
  logic [N-1:0] edge_trig, model, edge0, model0;

  int tests = 0, fails = 0;
  logic [N-1:0] me, mm, m0;

  irq_trig_cfg #(.NUM_IRQ(N), .LEGACY(LEG)) i_irq_trig_cfg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .err(err), .edge_trig(edge_trig), .model(model));
  irq_trig_cfg #(.NUM_IRQ(N), .LEGACY(1'b0)) i_irq_trig_cfg0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata0), .err(err0), .edge_trig(edge0), .model(model0));

  always #2.5 clk = ~clk;

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic int base_of(logic [11:0] a);
    return (int'(a) - 'hC00) * 4;
  endfunction

  function automatic logic [7:0] pack(logic [N-1:0] e, logic [N-1:0] m, int b);
    logic [7:0] v = 0;
    for (int k = 0; k < 4; k++)
      if (b + k < N) begin v[2*k+1] = e[b+k]; v[2*k] = m[b+k]; end
    return v;
  endfunction

  task automatic model_wr(logic [11:0] a, logic [7:0] d);
    int b;
    logic [7:0] v;
    if (a < 12'hC00 || a >= 12'hF00) return;
    b = base_of(a);
    if (b >= N) return;
    v = (b < 16) ? (d | 8'hAA) : d;
    for (int k = 0; k < 4; k++)
      if (b + k < N) begin me[b+k] = v[2*k+1]; mm[b+k] = v[2*k]; end
  endtask

  task automatic acc(logic w, logic [11:0] a, logic [7:0] d, string r);
    logic [7:0] exp_rd, prev_rd;
    logic in_w, bad;
    @(negedge clk);
    in_w = (a >= 12'hC00) && (a < 12'hF00);
    bad = in_w && base_of(a) >= N;
    prev_rd = rdata;
    exp_rd = (!w && in_w && !bad) ? pack(me, mm, base_of(a)) : prev_rd;
    addr = a; wdata = d; wr = w; rd = !w;
    if (w) model_wr(a, d);
    @(negedge clk);
    wr = 0; rd = 0;
    chk({r, " err"}, err, bad);
    chk({r, " edge"}, edge_trig, me);
    chk({r, " model"}, model, mm);
    if (!w) chk({r, " rdata"}, rdata, exp_rd);
  endtask

  initial begin
    void'($urandom(32'h1234));
    me = '0; me[15:0] = '1; mm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset edge", edge_trig, me);
    chk("R1 reset model", model, mm);
    // R3 SGI bytes forced
    acc(1, 12'hC00, 8'h00, "R3");
    acc(1, 12'hC03, 8'h55, "R3");
    acc(0, 12'hC03, 8'h00, "R6 sgi read");
    // R4 PPI writable
    acc(1, 12'hC04, 8'hAA, "R4");
    acc(1, 12'hC04, 8'h00, "R4");
    acc(1, 12'hC07, 8'h8A, "R4");
    acc(0, 12'hC07, 8'h00, "R6");
    // R2 shared
    acc(1, 12'hC10, 8'hC6, "R2");
    acc(0, 12'hC10, 8'h00, "R6");
    // last valid / first invalid: N=96 -> last byte 0xC17
    acc(1, 12'hC17, 8'hFF, "R2 last");
    acc(1, 12'hC18, 8'h00, "R7 bad wr");
    acc(0, 12'hC18, 8'h00, "R7 bad rd");
    acc(0, 12'hEFF, 8'h00, "R7 top");
    // R8 outside window
    acc(1, 12'hBFF, 8'h00, "R8 below");
    acc(0, 12'hF00, 8'h00, "R8 above");
    // R5 non-legacy instance
    chk("R5 model off", model0, '0);
    m0 = '0; m0[15:0] = '1; m0[27] = 1'b1; m0[26] = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a = 12'hBF0 + 12'($urandom_range(0, 'h40));
      if ($urandom_range(0, 9) == 0) a = 12'hF00 - 12'($urandom_range(0, 3));
      acc($urandom_range(0, 1) == 1, a, 8'($urandom), "R2 rand");
    end
    chk("R5 model off rand", model0, '0);
    chk("R5 legacy edge match", edge0, edge_trig);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule